// File: doc/BRIEF.md
# Dual-Sync Time-Slot B-Channel Port

This block carries two 8-bit bearer channels per 125 µs frame between parallel registers and one serial time-division stream. The transmit direction and the receive direction each follow their own frame sync. Each sync restarts a counter for its direction only, and that counter opens two byte slots back to back. Because the two directions are timed separately, any phase offset between them is tolerated. All serial timing runs as events inside one system clock domain: the edges of the bit clock are detected and turned into one-cycle rise and fall events.

In slave mode, the bit clock and both syncs come from outside. In master mode, the block divides its system clock to make the bit clock, counts the bits in each frame, and drives a single sync output that times both directions. A two-bit format code sets the master clock rate and so the number of bits in a frame. Serial data leaves on rising bit-clock edges and is sampled on falling edges, most significant bit first. Outside its slots the transmit pin is released, so several ports can share one bus.

Top module: `tdm_bport`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `dx_oe`, `rx_valid`, `bclk_out` and `fs_out` are all 0.
- R2: When the transmit sync is high at a falling bit-clock edge, the next 16 rising edges drive B1 and then B2 on `dx_out`, most significant bit first. `dx_oe` is high for exactly those 16 bit periods and low in the bit periods on either side of them.
- R3: When the receive sync is high at a falling bit-clock edge, the next 16 falling edges sample `dr_in`. The first 8 samples form B1 and the last 8 form B2, most significant bit first.
- R4: Each completed receive byte raises `rx_valid` for exactly one system clock. `rx_chan` is 0 for B1 and 1 for B2.
- R5: The transmit sync and the receive sync are independent. Any offset between them, in either order, leaves both directions correct.
- R6: In slave mode (`master`=0), the bit timing comes from `bclk_in`, and `bclk_out` and `fs_out` stay at 0.
- R7: In master mode, `bclk_out` is high for HALF_Fn system clocks and low for HALF_Fn system clocks. The format code sets n: `fmt` 0 gives format 1, 1 gives format 2, 2 gives format 3 and 3 gives format 4.
- R8: In master mode, a frame lasts 256, 32, 64 or 320 bit periods for `fmt` 0, 1, 2 or 3. `fs_out` is high during exactly the last bit period of each frame.
- R9: In master mode, `fs_out` times both directions, and `fsx_in` and `fsr_in` have no effect. Holding both inputs high still gives exactly 16 driven bits per frame.
- R10: The transmit bytes are captured when the transmit sync is sampled. A change to `tx_b1` after that point does not alter the bits sent in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| master | input | 1 | 1 = generate bit clock and sync, 0 = follow external timing |
| fmt | input | 2 | Format code; selects the master clock rate and frame length |
| bclk_in | input | 1 | External bit clock (slave mode) |
| fsx_in | input | 1 | Transmit frame sync (slave mode) |
| fsr_in | input | 1 | Receive frame sync (slave mode) |
| bclk_out | output | 1 | Generated bit clock (master mode) |
| fs_out | output | 1 | Generated frame sync for both directions (master mode) |
| tx_b1 | input | 8 | First transmit channel byte |
| tx_b2 | input | 8 | Second transmit channel byte |
| dx_out | output | 1 | Serial transmit data |
| dx_oe | output | 1 | Drive enable for `dx_out`; low outside the active slots |
| dr_in | input | 1 | Serial receive data |
| rx_data | output | 8 | Last received byte |
| rx_chan | output | 1 | Channel of `rx_data`: 0 = B1, 1 = B2 |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_data` |

## Verification
The assertions rely on two properties of the inputs. First, `bclk_in`, `fsx_in`, `fsr_in` and `dr_in` are synchronous to `clk`, and each level of `bclk_in` lasts at least two system clocks, so two falling events are never adjacent. Second, `master` and `fmt` change only while reset is held. The stimulus follows both rules: every level of the external bit clock is held for four system clocks, syncs and data change only at the start of a high phase, and the mode and format are set only inside a reset pulse before each master-mode sweep.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    localparam int SLOT_BITS  = 8;
    localparam int SLOT_COUNT = 2;
    localparam int FRAME_DATA = SLOT_BITS * SLOT_COUNT;
    localparam int SLOT_CW    = $clog2(FRAME_DATA + 1);
    localparam int FRAME_MAX  = 320;
    localparam int BITCNT_W   = $clog2(FRAME_MAX);
    localparam int DIV_W      = 16;

    typedef enum logic [1:0] {
        FMT_2M048 = 2'd0,
        FMT_256K  = 2'd1,
        FMT_512K  = 2'd2,
        FMT_2M560 = 2'd3
    } tdm_fmt_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } bit_evt_t;

    function automatic int unsigned frame_bits(tdm_fmt_e f);
        case (f)
            FMT_2M048: return 256;
            FMT_256K:  return 32;
            FMT_512K:  return 64;
            default:   return 320;
        endcase
    endfunction

endpackage

// File: rtl/tdm_bitclk.sv
module tdm_bitclk
    import tdm_pkg::*;
#(
    parameter int HALF_F1 = 12,
    parameter int HALF_F2 = 98,
    parameter int HALF_F3 = 49,
    parameter int HALF_F4 = 10
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     master,
    input  tdm_fmt_e fmt,
    input  logic     bclk_in,
    output bit_evt_t evt,
    output logic     bclk_out,
    output logic     fs_out
);

    logic [DIV_W-1:0]    div_cnt;
    logic [DIV_W-1:0]    half_lim;
    logic [BITCNT_W-1:0] bitcnt;
    logic [BITCNT_W-1:0] last_bit;
    logic                bclk_r;
    logic                bclk_q;
    logic                m_tog;

    always_comb begin
        case (fmt)
            FMT_2M048: half_lim = DIV_W'(HALF_F1);
            FMT_256K:  half_lim = DIV_W'(HALF_F2);
            FMT_512K:  half_lim = DIV_W'(HALF_F3);
            default:   half_lim = DIV_W'(HALF_F4);
        endcase
        last_bit = BITCNT_W'(frame_bits(fmt) - 1);
    end

    assign m_tog = master && (div_cnt >= half_lim - DIV_W'(1));

    always_comb begin
        if (master) begin
            evt.rise = m_tog && !bclk_r;
            evt.fall = m_tog &&  bclk_r;
        end else begin
            evt.rise =  bclk_in && !bclk_q;
            evt.fall = !bclk_in &&  bclk_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
            bclk_r  <= 1'b0;
            bclk_q  <= 1'b0;
            bitcnt  <= '0;
        end else begin
            bclk_q <= bclk_in;
            if (!master) begin
                div_cnt <= '0;
                bclk_r  <= 1'b0;
                bitcnt  <= '0;
            end else begin
                if (m_tog) begin
                    div_cnt <= '0;
                    bclk_r  <= !bclk_r;
                end else begin
                    div_cnt <= div_cnt + DIV_W'(1);
                end
                if (evt.rise)
                    bitcnt <= (bitcnt >= last_bit) ? '0 : bitcnt + BITCNT_W'(1);
            end
        end
    end

    assign bclk_out = bclk_r;
    assign fs_out   = master && (bitcnt == last_bit);

    AST_FS_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        master && $past(master) && $stable(fmt) && $fell(fs_out) |-> $past(evt.rise)); // R8

    AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !master && !$past(master) |-> !bclk_out && !fs_out); // R6

endmodule

// File: rtl/tdm_tx_slots.sv
module tdm_tx_slots
    import tdm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  bit_evt_t             evt,
    input  logic                 sync,
    input  logic [SLOT_BITS-1:0] b1,
    input  logic [SLOT_BITS-1:0] b2,
    output logic                 dx_out,
    output logic                 dx_oe
);

    logic [FRAME_DATA-1:0] sh;
    logic [SLOT_CW-1:0]    cnt;
    logic                  armed;
    logic                  rise;

    assign rise = evt.rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '0;
            cnt    <= '0;
            armed  <= 1'b0;
            dx_out <= 1'b0;
        end else if (evt.fall && sync) begin
            sh    <= {b1, b2};
            armed <= 1'b1;
        end else if (evt.rise) begin
            if (armed || (cnt != '0 && cnt < SLOT_CW'(FRAME_DATA))) begin
                dx_out <= sh[FRAME_DATA-1];
                sh     <= {sh[FRAME_DATA-2:0], 1'b0};
                cnt    <= armed ? SLOT_CW'(1) : cnt + SLOT_CW'(1);
                armed  <= 1'b0;
            end else begin
                cnt <= '0;
            end
        end
    end

    assign dx_oe = (cnt != '0);

    AST_TX_START: assert property (@(posedge clk) disable iff (rst)
        $rose(dx_oe) |-> $past(rise)); // R2

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(rise) |-> $stable(dx_out)); // R2

endmodule

// File: rtl/tdm_rx_slots.sv
module tdm_rx_slots
    import tdm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  bit_evt_t             evt,
    input  logic                 sync,
    input  logic                 dr_in,
    output logic [SLOT_BITS-1:0] rx_data,
    output logic                 rx_chan,
    output logic                 rx_valid
);

    logic [SLOT_BITS-1:0] sh;
    logic [SLOT_CW-1:0]   cnt;
    logic [SLOT_BITS-1:0] nxt;
    logic                 fall;

    assign fall = evt.fall;
    assign nxt  = {sh[SLOT_BITS-2:0], dr_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '0;
            cnt      <= '0;
            rx_data  <= '0;
            rx_chan  <= 1'b0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (evt.fall) begin
                if (sync) begin
                    cnt <= SLOT_CW'(1);
                end else if (cnt != '0) begin
                    sh <= nxt;
                    if (cnt == SLOT_CW'(SLOT_BITS) || cnt == SLOT_CW'(FRAME_DATA)) begin
                        rx_data  <= nxt;
                        rx_valid <= 1'b1;
                        rx_chan  <= (cnt == SLOT_CW'(FRAME_DATA));
                    end
                    cnt <= (cnt == SLOT_CW'(FRAME_DATA)) ? '0 : cnt + SLOT_CW'(1);
                end
            end
        end
    end

    AST_RX_PULSE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid); // R4

    AST_RX_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_valid) |-> $past(fall)); // R3

endmodule

// File: rtl/tdm_bport.sv
module tdm_bport
    import tdm_pkg::*;
#(
    parameter int HALF_F1 = 12,
    parameter int HALF_F2 = 98,
    parameter int HALF_F3 = 49,
    parameter int HALF_F4 = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       master,
    input  logic [1:0] fmt,
    input  logic       bclk_in,
    input  logic       fsx_in,
    input  logic       fsr_in,
    output logic       bclk_out,
    output logic       fs_out,
    input  logic [7:0] tx_b1,
    input  logic [7:0] tx_b2,
    output logic       dx_out,
    output logic       dx_oe,
    input  logic       dr_in,
    output logic [7:0] rx_data,
    output logic       rx_chan,
    output logic       rx_valid
);

    bit_evt_t evt;
    logic     tx_sync;
    logic     rx_sync;
    tdm_fmt_e fmt_e;

    assign fmt_e   = tdm_fmt_e'(fmt);
    assign tx_sync = master ? fs_out : fsx_in;
    assign rx_sync = master ? fs_out : fsr_in;

    tdm_bitclk #(
        .HALF_F1(HALF_F1), .HALF_F2(HALF_F2),
        .HALF_F3(HALF_F3), .HALF_F4(HALF_F4)
    ) u_clk (
        .clk(clk), .rst(rst), .master(master), .fmt(fmt_e),
        .bclk_in(bclk_in), .evt(evt), .bclk_out(bclk_out), .fs_out(fs_out)
    );

    tdm_tx_slots u_tx (
        .clk(clk), .rst(rst), .evt(evt), .sync(tx_sync),
        .b1(tx_b1), .b2(tx_b2), .dx_out(dx_out), .dx_oe(dx_oe)
    );

    tdm_rx_slots u_rx (
        .clk(clk), .rst(rst), .evt(evt), .sync(rx_sync), .dr_in(dr_in),
        .rx_data(rx_data), .rx_chan(rx_chan), .rx_valid(rx_valid)
    );

endmodule

// File: tb/tdm_bport_bench.sv
module tdm_bport_bench;

    localparam int H1 = 12, H2 = 98, H3 = 49, H4 = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic master = 1'b0;
    logic [1:0] fmt = 2'd0;
    logic bclk_in = 1'b0, fsx_in = 1'b0, fsr_in = 1'b0;
    logic bclk_out, fs_out;
    logic [7:0] tx_b1 = 8'h00, tx_b2 = 8'h00;
    logic dx_out, dx_oe;
    logic dr_bit = 1'b0, loop = 1'b0;
    logic dr_in;
    logic [7:0] rx_data;
    logic rx_chan, rx_valid;

    int vec = 0, bad = 0;
    int nval = 0;
    logic [7:0] got1, got2;

    assign dr_in = loop ? dx_out : dr_bit;

    always #10 clk = !clk;

    tdm_bport #(.HALF_F1(H1), .HALF_F2(H2), .HALF_F3(H3), .HALF_F4(H4)) u_tdm_bport (
        .clk(clk), .rst(rst), .master(master), .fmt(fmt),
        .bclk_in(bclk_in), .fsx_in(fsx_in), .fsr_in(fsr_in),
        .bclk_out(bclk_out), .fs_out(fs_out),
        .tx_b1(tx_b1), .tx_b2(tx_b2), .dx_out(dx_out), .dx_oe(dx_oe),
        .dr_in(dr_in), .rx_data(rx_data), .rx_chan(rx_chan), .rx_valid(rx_valid)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            if (rx_chan) got2 = rx_data;
            else         got1 = rx_data;
            nval++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bit_period(input logic fx, input logic fr, input logic d,
                              output logic dx, output logic oe);
        @(negedge clk);
        bclk_in = 1'b1; fsx_in = fx; fsr_in = fr; dr_bit = d;
        repeat (4) @(negedge clk);
        dx = dx_out; oe = dx_oe;
        bclk_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic slave_frame(input int toff, input int roff,
                               input logic [7:0] b1, input logic [7:0] b2,
                               input logic [7:0] r1, input logic [7:0] r2,
                               input bit mut);
        logic [15:0] tw, rw;
        logic dx, oe, d;
        int len, k;
        tw = {b1, b2}; rw = {r1, r2};
        tx_b1 = b1; tx_b2 = b2;
        len = ((toff > roff) ? toff : roff) + 19;
        nval = 0;
        for (int p = 0; p < len; p++) begin
            d = 1'b0;
            if (p > roff && p <= roff + 16) d = rw[15 - (p - roff - 1)];
            bit_period(p == toff, p == roff, d, dx, oe);
            if (p > toff && p <= toff + 16) begin
                k = p - toff - 1;
                // R2 R5 R10: slot bit k of B1/B2, MSB first
                chk(oe === 1'b1 && dx === tw[15 - k], mut ? "R10" : "R2",
                    int'({oe, dx}), int'({1'b1, tw[15 - k]}));
            end else begin
                chk(oe === 1'b0, "R2", int'(oe), 0);
            end
            if (mut && p == toff + 1) tx_b1 = ~b1;
        end
        chk(nval == 2, "R4", nval, 2);
        chk(got1 === r1, "R3", int'(got1), int'(r1));
        chk(got2 === r2, "R5", int'(got2), int'(r2));
        chk(bclk_out === 1'b0 && fs_out === 1'b0, "R6", int'({bclk_out, fs_out}), 0);
    endtask

    task automatic master_fmt(input logic [1:0] f, input int half, input int fb,
                              input logic [7:0] b1, input logic [7:0] b2);
        logic pb, pf;
        int fs_seen, rises, oebits, per, since;
        logic [15:0] acc;
        @(negedge clk);
        rst = 1'b1; master = 1'b1; fmt = f; loop = 1'b1;
        fsx_in = 1'b1; fsr_in = 1'b1; bclk_in = 1'b0;
        tx_b1 = b1; tx_b2 = b2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        pb = 1'b0; pf = 1'b0; fs_seen = 0; rises = 0; oebits = 0;
        per = 0; since = -1; acc = '0;
        while (fs_seen < 2) begin
            @(negedge clk);
            if (since >= 0) since++;
            if (bclk_out && !pb) begin
                if (since > 0) per = since;
                since = 0;
                if (fs_seen == 1) rises++;
            end
            if (!bclk_out && pb && fs_seen == 1 && dx_oe) begin
                oebits++;
                acc = {acc[14:0], dx_out};
            end
            if (fs_out && !pf) begin
                fs_seen++;
                if (fs_seen == 1) nval = 0;
            end
            pb = bclk_out; pf = fs_out;
        end
        chk(per == 2 * half, "R7", per, 2 * half);
        chk(rises == fb, "R8", rises, fb);
        chk(oebits == 16, "R9", oebits, 16);
        chk(acc === {b1, b2}, "R9", int'(acc), int'({b1, b2}));
        chk(nval == 2 && got1 === b1 && got2 === b2, "R3", int'({got1, got2}), int'({b1, b2}));
        @(negedge clk);
        rst = 1'b1; master = 1'b0; loop = 1'b0; fsx_in = 1'b0; fsr_in = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(dx_oe === 0 && rx_valid === 0 && bclk_out === 0 && fs_out === 0, "R1",
            int'({dx_oe, rx_valid, bclk_out, fs_out}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(dx_oe === 0 && rx_valid === 0 && bclk_out === 0 && fs_out === 0, "R1",
            int'({dx_oe, rx_valid, bclk_out, fs_out}), 0);

        slave_frame(0, 0, 8'hA5, 8'h3C, 8'h96, 8'h0F, 1'b0);
        slave_frame(0, 5, 8'hFF, 8'h00, 8'h01, 8'h80, 1'b0);   // R5 rx later
        slave_frame(7, 2, 8'h81, 8'h7E, 8'hC3, 8'h5A, 1'b0);   // R5 tx later
        slave_frame(3, 3, 8'h00, 8'hFF, 8'hFF, 8'h00, 1'b0);
        slave_frame(1, 4, 8'h6D, 8'hB2, 8'h24, 8'hE7, 1'b1);   // R10 late change

        master_fmt(2'd0, H1, 256, 8'hC5, 8'h1E);
        master_fmt(2'd1, H2, 32,  8'h3A, 8'hF0);
        master_fmt(2'd2, H3, 64,  8'h99, 8'h42);
        master_fmt(2'd3, H4, 320, 8'h07, 8'hE8);

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule